// File: doc/BRIEF.md
# Compressed Opcode Page Stack

This block tracks which alternate 16-bit opcode page the front end should decode with, and for how many more instructions. A page-select command pushes an entry onto a four-level stack. Each entry holds a 3-bit subpage number and a 4-bit activation length. The entry on top of the stack is the active page. When the stack is empty, the base instruction set is in force. The length of the top entry counts down as instructions retire, and the entry is removed when it runs out. The length value 15 marks a page that stays active with no countdown.

A taken branch ends the active page by removing one level. There are two explicit commands. One returns the stack to the base set at once. The other removes a single level. The stack and its depth are also presented as one control word, and a whole control word can be loaded back. This lets software save the page state and restore it across a context switch. Decoding of instructions inside a page is outside this block.

All commands are single-cycle strobes sampled on the rising clock edge. The block never stalls a command, so none of its pins carries back-pressure. When several strobes arrive in the same cycle, only the one with the highest priority takes effect.

Top module: `cpage_stack`

## Requirements
- R1: After reset, and one cycle after `def_i`, the depth, active page and remaining length are all 0, `active_o` is low and `ovf_o` is low. `def_i` has the highest priority of all commands.
- R2: A page-select (`sel_i`) with a nonzero length at a depth below 4 places {page, length} on top of the stack. In the next cycle the depth has gone up by 1, and `page_o`/`len_o` show the new entry.
- R3: A page-select with a nonzero length at depth 4 leaves the stack unchanged. It drives `ovf_o` high for exactly the next cycle. `ovf_o` is never high otherwise.
- R4: A page-select with length 0 leaves the stack unchanged and does not raise `ovf_o`.
- R5: A retire (`ret_i`) when the top length is between 2 and 14 lowers that length by 1 and keeps the depth.
- R6: A retire when the top length is 1 removes the top entry, which exposes the entry beneath it unchanged.
- R7: A top length of 15 is permanent: a retire leaves the length and the depth unchanged. A retire at depth 0 has no effect.
- R8: A branch (`brn_i`) at nonzero depth removes exactly one level, even a permanent one. A retire in the same cycle is discarded, so the entry beneath keeps its length.
- R9: A pop command (`pop_i`) removes exactly one level. At depth 0 it has no effect. A branch and a pop in the same cycle remove only one level.
- R10: The command priority is `def_i` > `ld_i` > `brn_i`/`pop_i` > `sel_i` > `ret_i`. Only the highest-priority asserted command acts in a cycle.
- R11: `ctx_o` holds the depth in bits [30:28]. It holds stack slot k (slot 0 is the bottom) in bits [7k+6:7k], with the page in the upper 3 bits and the length in the lower 4 bits. Slots at or above the depth read as zero.
- R12: `ld_i` loads `ld_ctx_i`, which uses the same layout as `ctx_o`. A depth field above 4 is clamped to 4. Slots at or above the loaded depth are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| def_i | input | 1 | Return to the base instruction set (clear the stack) |
| ld_i | input | 1 | Load the saved control word |
| ld_ctx_i | input | 31 | Control word to load |
| brn_i | input | 1 | Taken branch: ends the active page |
| pop_i | input | 1 | Remove one stack level |
| sel_i | input | 1 | Page-select command |
| sel_page_i | input | 3 | Subpage number of the page-select |
| sel_len_i | input | 4 | Activation length of the page-select (15 = permanent) |
| ret_i | input | 1 | Instruction retire strobe |
| page_o | output | 3 | Active subpage (0 when empty) |
| len_o | output | 4 | Remaining length of the active page (0 when empty) |
| depth_o | output | 3 | Current stack depth |
| active_o | output | 1 | An alternate page is active |
| ovf_o | output | 1 | A page-select was refused because the stack was full |
| ctx_o | output | 31 | Control word for saving the state |

## Verification
The assertions assume that every strobe is at a known 0 or 1 from the first edge after reset. Each property states its own priority guard, for example "retire with no higher command". Because of this, a property about one command stays quiet when a stronger command arrives in the same cycle. The bench drives every input to a defined value on each falling edge. It mixes weighted random strobes with frequent co-asserted commands, lengths biased toward 0, 1 and 15, and arbitrary 31-bit load words, including depth fields above 4. This way every priority pairing and clamp path is reached, and all inputs stay within those assumptions.

// File: rtl/cpage_pkg.sv
package cpage_pkg;
  localparam int PAGE_W    = 3;
  localparam int LEN_W     = 4;
  localparam int STK_DEPTH = 4;
  localparam int DEPTH_W   = $clog2(STK_DEPTH + 1);
  localparam int IDX_W     = $clog2(STK_DEPTH);
  localparam int ENTRY_W   = PAGE_W + LEN_W;
  localparam int CTX_W     = STK_DEPTH * ENTRY_W + DEPTH_W;
  localparam logic [LEN_W-1:0] PERM_LEN = '1;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [LEN_W-1:0]  len;
  } entry_t;

  typedef enum logic [2:0] {
    OP_HOLD, OP_CLEAR, OP_LOAD, OP_POP, OP_PUSH, OP_DEC
  } op_e;
endpackage

// File: rtl/cpage_ctrl.sv
module cpage_ctrl
  import cpage_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               def_i,
  input  logic               ld_i,
  input  logic               brn_i,
  input  logic               pop_i,
  input  logic               sel_i,
  input  logic [LEN_W-1:0]   sel_len_i,
  input  logic               ret_i,
  input  logic [LEN_W-1:0]   top_len_i,
  input  logic [DEPTH_W-1:0] ld_depth_i,
  output op_e                op_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               ovf_o
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(STK_DEPTH);
  localparam logic [LEN_W-1:0]   ONE  = LEN_W'(1);

  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic               ovf_q, ovf_set;
  logic               empty, full;
  op_e                op;

  assign empty = (depth_q == '0);
  assign full  = (depth_q == FULL);

  // fixed priority: clear, load, unwind, push, countdown
  always_comb begin
    op      = OP_HOLD;
    ovf_set = 1'b0;
    if (def_i)                op = OP_CLEAR;
    else if (ld_i)            op = OP_LOAD;
    else if (brn_i || pop_i) begin
      if (!empty)             op = OP_POP;
    end
    else if (sel_i) begin
      if (sel_len_i != '0) begin
        if (full)             ovf_set = 1'b1;
        else                  op = OP_PUSH;
      end
    end
    else if (ret_i && !empty && top_len_i != PERM_LEN) begin
      op = (top_len_i == ONE) ? OP_POP : OP_DEC;
    end
  end

  always_comb begin
    unique case (op)
      OP_CLEAR: depth_d = '0;
      OP_LOAD:  depth_d = ld_depth_i;
      OP_POP:   depth_d = depth_q - DEPTH_W'(1);
      OP_PUSH:  depth_d = depth_q + DEPTH_W'(1);
      default:  depth_d = depth_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      depth_q <= depth_d;
      ovf_q   <= ovf_set;
    end
  end

  assign op_o    = op;
  assign depth_o = depth_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/cpage_store.sv
module cpage_store
  import cpage_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  op_e                        op_i,
  input  logic [DEPTH_W-1:0]         depth_i,
  input  entry_t                     push_i,
  input  entry_t [STK_DEPTH-1:0]     load_i,
  output entry_t [STK_DEPTH-1:0]     slots_o
);
  entry_t [STK_DEPTH-1:0] slot_q;

  for (genvar k = 0; k < STK_DEPTH; k++) begin : g_slot
    logic is_top, is_next;
    assign is_top  = (depth_i == DEPTH_W'(k + 1));
    assign is_next = (depth_i == DEPTH_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[k] <= '0;
      end else begin
        unique case (op_i)
          OP_CLEAR: slot_q[k] <= '0;
          OP_LOAD:  slot_q[k] <= load_i[k];
          OP_POP:   if (is_top)  slot_q[k] <= '0;
          OP_PUSH:  if (is_next) slot_q[k] <= push_i;
          OP_DEC:   if (is_top)  slot_q[k].len <= slot_q[k].len - LEN_W'(1);
          default:  ;
        endcase
      end
    end
  end

  assign slots_o = slot_q;
endmodule

// File: rtl/cpage_ctx.sv
module cpage_ctx
  import cpage_pkg::*;
(
  input  entry_t [STK_DEPTH-1:0] slots_i,
  input  logic [DEPTH_W-1:0]     depth_i,
  input  logic [CTX_W-1:0]       ctx_i,
  output logic [CTX_W-1:0]       ctx_o,
  output entry_t [STK_DEPTH-1:0] ld_slots_o,
  output logic [DEPTH_W-1:0]     ld_depth_o
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(STK_DEPTH);

  logic [DEPTH_W-1:0] raw_depth;
  assign raw_depth  = ctx_i[CTX_W-1 -: DEPTH_W];
  assign ld_depth_o = (raw_depth > FULL) ? FULL : raw_depth;

  assign ctx_o[CTX_W-1 -: DEPTH_W] = depth_i;

  for (genvar k = 0; k < STK_DEPTH; k++) begin : g_pack
    assign ctx_o[k*ENTRY_W +: ENTRY_W] = slots_i[k];
    assign ld_slots_o[k] = (DEPTH_W'(k) < ld_depth_o) ? entry_t'(ctx_i[k*ENTRY_W +: ENTRY_W])
                                                      : entry_t'('0);
  end
endmodule

// File: rtl/cpage_stack.sv
module cpage_stack
  import cpage_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               def_i,
  input  logic               ld_i,
  input  logic [CTX_W-1:0]   ld_ctx_i,
  input  logic               brn_i,
  input  logic               pop_i,
  input  logic               sel_i,
  input  logic [PAGE_W-1:0]  sel_page_i,
  input  logic [LEN_W-1:0]   sel_len_i,
  input  logic               ret_i,
  output logic [PAGE_W-1:0]  page_o,
  output logic [LEN_W-1:0]   len_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               active_o,
  output logic               ovf_o,
  output logic [CTX_W-1:0]   ctx_o
);
  op_e                    op;
  logic [DEPTH_W-1:0]     depth;
  logic [DEPTH_W-1:0]     ld_depth;
  entry_t [STK_DEPTH-1:0] slots, ld_slots;
  entry_t                 top, push_ent;
  logic [DEPTH_W-1:0]     top_idx;

  assign push_ent = '{page: sel_page_i, len: sel_len_i};
  assign top_idx  = depth - DEPTH_W'(1);
  assign top      = (depth == '0) ? entry_t'('0) : slots[top_idx[IDX_W-1:0]];

  cpage_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .def_i      (def_i),
    .ld_i       (ld_i),
    .brn_i      (brn_i),
    .pop_i      (pop_i),
    .sel_i      (sel_i),
    .sel_len_i  (sel_len_i),
    .ret_i      (ret_i),
    .top_len_i  (top.len),
    .ld_depth_i (ld_depth),
    .op_o       (op),
    .depth_o    (depth),
    .ovf_o      (ovf_o)
  );

  cpage_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op),
    .depth_i (depth),
    .push_i  (push_ent),
    .load_i  (ld_slots),
    .slots_o (slots)
  );

  cpage_ctx u_ctx (
    .slots_i    (slots),
    .depth_i    (depth),
    .ctx_i      (ld_ctx_i),
    .ctx_o      (ctx_o),
    .ld_slots_o (ld_slots),
    .ld_depth_o (ld_depth)
  );

  assign page_o   = top.page;
  assign len_o    = top.len;
  assign depth_o  = depth;
  assign active_o = (depth != '0);
endmodule

// File: rtl/cpage_stack_chk.sv
module cpage_stack_chk
  import cpage_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               def_i,
  input logic               ld_i,
  input logic [CTX_W-1:0]   ld_ctx_i,
  input logic               brn_i,
  input logic               pop_i,
  input logic               sel_i,
  input logic [PAGE_W-1:0]  sel_page_i,
  input logic [LEN_W-1:0]   sel_len_i,
  input logic               ret_i,
  input logic [PAGE_W-1:0]  page_o,
  input logic [LEN_W-1:0]   len_o,
  input logic [DEPTH_W-1:0] depth_o,
  input logic               active_o,
  input logic               ovf_o,
  input logic [CTX_W-1:0]   ctx_o
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(STK_DEPTH);

  logic no_high, only_unwind, full_push, only_ret;
  assign no_high     = !def_i && !ld_i;
  assign only_unwind = no_high && (brn_i || pop_i);
  assign full_push   = no_high && !brn_i && !pop_i && sel_i && sel_len_i != '0 && depth_o == FULL;
  assign only_ret    = no_high && !brn_i && !pop_i && !sel_i && ret_i;

  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    def_i |=> (depth_o == '0 && !active_o && len_o == '0 && page_o == '0));

  // R2
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= FULL);

  // R3
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_push |=> (ovf_o && $stable(depth_o) && $stable(ctx_o)));

  // R3
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(full_push));

  // R5
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_ret && active_o && len_o > LEN_W'(1) && len_o != PERM_LEN)
      |=> (len_o == LEN_W'($past(len_o) - LEN_W'(1)) && $stable(depth_o)));

  // R7
  permanent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_ret && len_o == PERM_LEN) |=> (len_o == PERM_LEN && $stable(depth_o)));

  // R8
  unwind_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_unwind && active_o) |=> (depth_o == DEPTH_W'($past(depth_o) - DEPTH_W'(1))));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_unwind && !active_o) |=> (depth_o == '0));
endmodule

bind cpage_stack cpage_stack_chk u_chk (.*);

// File: tb/cpage_stack_test.sv
`timescale 1ns/1ps
module cpage_stack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        def_i = 0, ld_i = 0, brn_i = 0, pop_i = 0, sel_i = 0, ret_i = 0;
  logic [30:0] ld_ctx_i = '0;
  logic [2:0]  sel_page_i = '0;
  logic [3:0]  sel_len_i = '0;
  logic [2:0]  page_o;
  logic [3:0]  len_o;
  logic [2:0]  depth_o;
  logic        active_o, ovf_o;
  logic [30:0] ctx_o;

  int checks = 0;
  int fails  = 0;

  logic [2:0] m_pg [4];
  logic [3:0] m_ln [4];
  int         m_d;
  logic       m_ovf;

  always #2.5 clk = ~clk;

  cpage_stack uut (.*);

  function automatic logic [42:0] expect_vec();
    logic [30:0] c;
    logic [2:0] pg;
    logic [3:0] ln;
    c = '0;
    c[30:28] = 3'(m_d);
    for (int k = 0; k < 4; k++) c[7*k +: 7] = {m_pg[k], m_ln[k]};
    pg = (m_d > 0) ? m_pg[m_d-1] : 3'd0;
    ln = (m_d > 0) ? m_ln[m_d-1] : 4'd0;
    return {pg, ln, 3'(m_d), (m_d > 0), m_ovf, c};
  endfunction

  function automatic void m_clear();
    for (int k = 0; k < 4; k++) begin m_pg[k] = '0; m_ln[k] = '0; end
    m_d = 0;
  endfunction

  function automatic void m_pop();
    if (m_d > 0) begin
      m_d = m_d - 1;
      m_pg[m_d] = '0;
      m_ln[m_d] = '0;
    end
  endfunction

  function automatic string model(logic d, logic l, logic b, logic p, logic s, logic r,
                                  logic [2:0] pg, logic [3:0] ln, logic [30:0] cx);
    string req;
    int nd;
    m_ovf = 1'b0;
    if (d) begin m_clear(); req = "R1"; end
    else if (l) begin
      nd = int'(cx[30:28]);
      if (nd > 4) nd = 4;
      for (int k = 0; k < 4; k++) begin
        m_pg[k] = (k < nd) ? cx[7*k+4 +: 3] : 3'd0;
        m_ln[k] = (k < nd) ? cx[7*k +: 4] : 4'd0;
      end
      m_d = nd;
      req = "R12";
    end
    else if (b) begin m_pop(); req = "R8"; end
    else if (p) begin m_pop(); req = "R9"; end
    else if (s) begin
      if (ln == 0) req = "R4";
      else if (m_d == 4) begin m_ovf = 1'b1; req = "R3"; end
      else begin m_pg[m_d] = pg; m_ln[m_d] = ln; m_d++; req = "R2"; end
    end
    else if (r) begin
      if (m_d == 0 || m_ln[m_d-1] == 4'hF) req = "R7";
      else if (m_ln[m_d-1] == 4'd1) begin m_pop(); req = "R6"; end
      else begin m_ln[m_d-1] = m_ln[m_d-1] - 4'd1; req = "R5"; end
    end
    else req = "R10";
    if (int'(d) + int'(l) + int'(b || p) + int'(s) + int'(r) > 1) req = {req, "/R10"};
    return req;
  endfunction

  task automatic check(string req, logic [42:0] act, logic [42:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(logic d, logic l, logic b, logic p, logic s, logic r,
                     logic [2:0] pg, logic [3:0] ln, logic [30:0] cx);
    string req;
    def_i = d; ld_i = l; brn_i = b; pop_i = p; sel_i = s; ret_i = r;
    sel_page_i = pg; sel_len_i = ln; ld_ctx_i = cx;
    @(posedge clk);
    req = model(d, l, b, p, s, r, pg, ln, cx);
    @(negedge clk);
    def_i = 0; ld_i = 0; brn_i = 0; pop_i = 0; sel_i = 0; ret_i = 0;
    check(req, {page_o, len_o, depth_o, active_o, ovf_o, ctx_o}, expect_vec());
  endtask

  task automatic push(logic [2:0] pg, logic [3:0] ln);
    cyc(0, 0, 0, 0, 1, 0, pg, ln, '0);
  endtask

  task automatic retire();
    cyc(0, 0, 0, 0, 0, 1, '0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    m_clear();
    m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {page_o, len_o, depth_o, active_o, ovf_o, ctx_o}, expect_vec());

    // R2 / R11 packing
    push(3'd5, 4'd3);
    push(3'd2, 4'hF);
    check("R11", {12'd0, ctx_o}, {12'd0, 31'h200017D3});
    // R7 permanent top
    retire();
    retire();
    // R8 branch + retire: only pop, entry below keeps length 3
    cyc(0, 0, 1, 0, 0, 1, '0, '0, '0);
    // R5 then R6 auto pop
    retire();
    retire();
    retire();
    // R9 pop at zero depth
    cyc(0, 0, 0, 1, 0, 0, '0, '0, '0);
    // R4 zero length push
    push(3'd6, 4'd0);
    // R3 fill and overflow
    for (int k = 0; k < 4; k++) push(3'(k + 1), 4'(k + 2));
    push(3'd7, 4'd9);
    push(3'd7, 4'd0);
    // R9 branch and pop together remove one level
    cyc(0, 0, 1, 1, 0, 0, '0, '0, '0);
    // R10 clear beats push
    cyc(1, 0, 0, 0, 1, 0, 3'd4, 4'd4, '0);
    // R12 load with depth 7 clamps to 4
    cyc(0, 1, 0, 0, 0, 0, '0, '0, 31'h7ABC_DEF1);
    // R12 load depth 1 clears upper slots; R10 load beats branch
    cyc(0, 1, 1, 0, 0, 0, '0, '0, {3'd1, 28'hFFF_FF25});
    cyc(1, 0, 0, 0, 0, 0, '0, '0, '0);

    for (int n = 0; n < 6000; n++) begin
      logic d, l, b, p, s, r;
      logic [3:0] ln;
      int w;
      d = ($urandom % 100) < 2;
      l = ($urandom % 100) < 3;
      b = ($urandom % 100) < 8;
      p = ($urandom % 100) < 8;
      s = ($urandom % 100) < 35;
      r = ($urandom % 100) < 55;
      w = $urandom % 8;
      ln = (w == 0) ? 4'd0 : (w == 1) ? 4'd1 : (w == 2) ? 4'hF : 4'($urandom);
      cyc(d, l, b, p, s, r, 3'($urandom), ln, 31'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule